// File: doc/BRIEF.md
# Per-Ring Interrupt Status Aggregator

This block gathers three kinds of per-ring event pulses from a multi-ring DMA host interface: transmit complete, receive complete and receive overflow. It latches them into a bank of 32-bit status words that software reads, and each read clears the word it returns. A second bank of per-ring enable bits decides which pending events may raise the single interrupt request. A read-only word reports the ring count. A control word selects an auto-clear mode, in which the request is a one-cycle pulse.

The request is a level. Once it has fired, the block is disarmed. It re-arms only after software has read every status word at least once since that firing. This applies even to words whose rings are all disabled. Pending events that remain, or that arrive later, then raise the request again.

Register access is a simple synchronous port. The 6-bit address splits into a region selector (address bits 5:4) and a word index (bits 3:0). The regions are: 0 for status, 1 for enable, 2 for the ring count and 3 for control. Read data is registered. It appears after the clock edge that samples `rdEn` and holds until the next read.

Top module: `irq_agg`

## Requirements
- R1: With N rings, status bit g is word g/32, bit g%32, at address 0x00+word. Transmit ring r is at g=r, receive ring r at g=N+r, and receive overflow ring r at g=2N+r. An event pulse sampled at a clock edge sets its bit at that edge.
- R2: The status bank has (31+3N)/32 words. A read returns the word's pending bits on `rdData` after the sampling edge and clears them at that same edge.
- R3: An event sampled in the same cycle as a read of its word is returned as 0 by that read and stays pending for the next read.
- R4: The enable bank has (31+2N)/32 words at address 0x10+word. Receive ring r is enable bit r and transmit ring r is enable bit N+r; the bank reads back as written. Transmit events are gated by the transmit bit; receive and overflow events are gated by the receive bit of the same ring.
- R5: When the block is armed and a pending bit has its enable set at an edge, `irq` is high from that edge on. For an event sampled at edge k, `irq` rises at edge k+1.
- R6: Outside auto-clear mode, `irq` stays high until the edge that samples the first status read after it rose.
- R7: After `irq` rises, it cannot rise again until every status word has been read since that rise. It can rise again two edges after the final such read.
- R8: Control word address 0x30, bit 2, enables auto-clear and reads back; in this mode `irq` is high for exactly one cycle per firing.
- R9: Address 0x20 reads the ring count in bits 10:0. Writes to it have no effect.
- R10: Enable bits at or above 2N, status bits at or above 3N, status words past the bank and unused addresses read 0 and ignore writes.
- R11: After reset, all status and enable bits are 0, auto-clear is off, the block is armed and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| addr | input | 6 | Region (5:4) and word index (3:0) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| evtTx | input | RING_CNT | Per-ring transmit-done pulses |
| evtRx | input | RING_CNT | Per-ring receive-done pulses |
| evtOvf | input | RING_CNT | Per-ring receive-overflow pulses |
| irq | output | 1 | Interrupt request level |

## Verification
An event sampled at edge k is visible in status at k and raises `irq` at k+1. Read data and the read's clearing effect, including the drop of `irq`, appear at the edge that samples the read. Re-arming takes one further edge, so a held-back request reappears two edges after the last outstanding status read. The bench drives and samples on falling edges. Its behavioural model applies these latencies on every rising edge, and directed checks sample `irq` at the exact falling edges where a rise or fall is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int IDX_W = 4;
  localparam int ADDR_W = IDX_W + 2;

  typedef enum logic [1:0] {
    RG_STAT = 2'd0,
    RG_EN   = 2'd1,
    RG_CNT  = 2'd2,
    RG_CFG  = 2'd3
  } regionT;

  typedef struct packed {
    logic             statRd;
    logic             enWr;
    logic             cfgWr;
    logic             rdCap;
    regionT           region;
    logic [IDX_W-1:0] idx;
  } strobeT;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int STAT_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hitAny,
  input  logic              autoClr,
  output strobeT            strobe,
  output logic              irq
);
  localparam logic [IDX_W:0] SW_LIM = (IDX_W+1)'(STAT_WORDS);

  logic                  armed;
  logic [STAT_WORDS-1:0] seenVec;
  logic [STAT_WORDS-1:0] seenHit;
  logic                  fire;

  always_comb begin
    strobe.region = regionT'(addr[ADDR_W-1:IDX_W]);
    strobe.idx    = addr[IDX_W-1:0];
    strobe.rdCap  = rdEn;
    strobe.statRd = rdEn && (strobe.region == RG_STAT) && ({1'b0, strobe.idx} < SW_LIM);
    strobe.enWr   = wrEn && (strobe.region == RG_EN);
    strobe.cfgWr  = wrEn && (strobe.region == RG_CFG) && (strobe.idx == '0);
  end

  always_comb begin
    for (int w = 0; w < STAT_WORDS; w++)
      seenHit[w] = strobe.statRd && (strobe.idx == IDX_W'(w));
  end

  assign fire = armed && hitAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b1;
      seenVec <= '0;
      irq     <= 1'b0;
    end else if (fire) begin
      irq     <= 1'b1;
      armed   <= 1'b0;
      seenVec <= '0;
    end else begin
      seenVec <= seenVec | seenHit;
      if (!armed && (&seenVec)) armed <= 1'b1;
      if (irq && (strobe.statRd || autoClr)) irq <= 1'b0;
    end
  end

  // R7: a disarmed block cannot raise the request on the next edge
  assert_no_refire_R7: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !$rose(irq));

  // R5: a rising request always has an enabled pending cause
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(hitAny));

  // R8: auto-clear keeps the request to a single cycle
  assert_autoclr_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && autoClr) |=> !irq);

  // R6: a status read drops the request
  assert_read_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irq && strobe.statRd) |=> !irq);
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int RING_CNT   = 12,
  parameter int STAT_WORDS = 2,
  parameter int EN_WORDS   = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [31:0]         wrData,
  input  logic [RING_CNT-1:0] evtTx,
  input  logic [RING_CNT-1:0] evtRx,
  input  logic [RING_CNT-1:0] evtOvf,
  output logic [31:0]         rdData,
  output logic                hitAny,
  output logic                autoClr
);
  localparam int SB = STAT_WORDS * 32;
  localparam int EB = EN_WORDS * 32;
  localparam logic [10:0] CNT11 = 11'(RING_CNT);

  function automatic logic [EB-1:0] lowOnes(input int n);
    logic [EB-1:0] v;
    v = '0;
    for (int i = 0; i < EB; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  localparam logic [EB-1:0] EN_VALID = lowOnes(2 * RING_CNT);

  logic [SB-1:0] pend;
  logic [SB-1:0] newEvt;
  logic [SB-1:0] clrMask;
  logic [EB-1:0] enReg;
  logic [31:0]   rdNext;

  always_comb begin
    newEvt = '0;
    newEvt[RING_CNT-1:0]            = evtTx;
    newEvt[2*RING_CNT-1:RING_CNT]   = evtRx;
    newEvt[3*RING_CNT-1:2*RING_CNT] = evtOvf;
  end

  for (genvar w = 0; w < STAT_WORDS; w++) begin : gClr
    assign clrMask[w*32 +: 32] = {32{strobe.statRd && (strobe.idx == IDX_W'(w))}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= '0;
    else       pend <= (pend & ~clrMask) | newEvt;
  end

  for (genvar w = 0; w < EN_WORDS; w++) begin : gEn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        enReg[w*32 +: 32] <= '0;
      else if (strobe.enWr && (strobe.idx == IDX_W'(w)))
        enReg[w*32 +: 32] <= wrData & EN_VALID[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             autoClr <= 1'b0;
    else if (strobe.cfgWr) autoClr <= wrData[2];
  end

  assign hitAny = |(pend[RING_CNT-1:0] & enReg[2*RING_CNT-1:RING_CNT])
                | |(pend[2*RING_CNT-1:RING_CNT] & enReg[RING_CNT-1:0])
                | |(pend[3*RING_CNT-1:2*RING_CNT] & enReg[RING_CNT-1:0]);

  always_comb begin
    rdNext = '0;
    unique case (strobe.region)
      RG_STAT: for (int w = 0; w < STAT_WORDS; w++)
                 if (strobe.idx == IDX_W'(w)) rdNext = pend[w*32 +: 32];
      RG_EN:   for (int w = 0; w < EN_WORDS; w++)
                 if (strobe.idx == IDX_W'(w)) rdNext = enReg[w*32 +: 32];
      RG_CNT:  if (strobe.idx == '0) rdNext = {21'b0, CNT11};
      RG_CFG:  if (strobe.idx == '0) rdNext = {29'b0, autoClr, 2'b0};
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdCap) rdData <= rdNext;
  end

  // R3: an arriving event is pending after the edge, whatever the read did
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|newEvt) |=> ((pend & $past(newEvt)) == $past(newEvt)));

  // R2: a status read with no concurrent events leaves its word empty
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statRd && (newEvt == '0)) |=> ((pend & $past(clrMask)) == '0));
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int RING_CNT = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic [5:0]          addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [RING_CNT-1:0] evtTx,
  input  logic [RING_CNT-1:0] evtRx,
  input  logic [RING_CNT-1:0] evtOvf,
  output logic                irq
);
  localparam int STAT_WORDS = (31 + 3 * RING_CNT) / 32;
  localparam int EN_WORDS   = (31 + 2 * RING_CNT) / 32;

  strobeT strobe;
  logic   hitAny;
  logic   autoClr;

  irq_agg_ctrl #(.STAT_WORDS(STAT_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .hitAny(hitAny), .autoClr(autoClr), .strobe(strobe), .irq(irq)
  );

  irq_agg_dp #(.RING_CNT(RING_CNT), .STAT_WORDS(STAT_WORDS), .EN_WORDS(EN_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .evtTx(evtTx), .evtRx(evtRx), .evtOvf(evtOvf),
    .rdData(rdData), .hitAny(hitAny), .autoClr(autoClr)
  );
endmodule

// File: tb/irq_agg_test.sv
`timescale 1ns/1ps
module irq_agg_test;
  localparam int N  = 12;
  localparam int SW = (31 + 3 * N) / 32;
  localparam int EW = (31 + 2 * N) / 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [N-1:0] evtTx = '0, evtRx = '0, evtOvf = '0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg #(.RING_CNT(N)) uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtTx(evtTx), .evtRx(evtRx),
    .evtOvf(evtOvf), .irq(irq)
  );

  // behavioural reference model
  bit pendM [SW*32];
  bit enM   [EW*32];
  bit seenM [SW];
  bit armedM, irqM, autoM;
  logic [31:0] rdM;

  always @(posedge clk or negedge rstN) begin : model
    int region, idx;
    bit hit, fire, sRd, allSeen;
    if (!rstN) begin
      foreach (pendM[i]) pendM[i] = 0;
      foreach (enM[i]) enM[i] = 0;
      foreach (seenM[i]) seenM[i] = 0;
      armedM = 1; irqM = 0; autoM = 0; rdM = '0;
    end else begin
      region = int'(addr[5:4]);
      idx = int'(addr[3:0]);
      hit = 0;
      for (int r = 0; r < N; r++)
        if ((pendM[r] && enM[N+r]) || (pendM[N+r] && enM[r]) || (pendM[2*N+r] && enM[r])) hit = 1;
      fire = armedM && hit;
      sRd = rdEn && region == 0 && idx < SW;
      allSeen = 1;
      foreach (seenM[w]) if (!seenM[w]) allSeen = 0;
      if (rdEn) begin
        rdM = '0;
        if (region == 0 && idx < SW) for (int b = 0; b < 32; b++) rdM[b] = pendM[idx*32+b];
        else if (region == 1 && idx < EW) for (int b = 0; b < 32; b++) rdM[b] = enM[idx*32+b];
        else if (region == 2 && idx == 0) rdM = N;
        else if (region == 3 && idx == 0) rdM = autoM ? 32'h4 : 32'h0;
      end
      if (fire) begin
        irqM = 1; armedM = 0;
        foreach (seenM[w]) seenM[w] = 0;
      end else begin
        if (sRd) seenM[idx] = 1;
        if (!armedM && allSeen) armedM = 1;
        if (irqM && (sRd || autoM)) irqM = 0;
      end
      if (sRd) for (int b = 0; b < 32; b++) pendM[idx*32+b] = 0;
      for (int r = 0; r < N; r++) begin
        if (evtTx[r]) pendM[r] = 1;
        if (evtRx[r]) pendM[N+r] = 1;
        if (evtOvf[r]) pendM[2*N+r] = 1;
      end
      if (wrEn && region == 1 && idx < EW)
        for (int b = 0; b < 32; b++) if (idx*32+b < 2*N) enM[idx*32+b] = wrData[b];
      if (wrEn && region == 3 && idx == 0) autoM = wrData[2];
    end
  end

  // R5 / R2: cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (irq !== irqM) begin
        fails++;
        $display("FAIL R5 model irq actual=%0b expected=%0b at %0t", irq, irqM, $time);
      end
      checks++;
      if (rdData !== rdM) begin
        fails++;
        $display("FAIL R2 model rdData actual=%08h expected=%08h at %0t", rdData, rdM, $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulse(input int kind, input logic [N-1:0] m);
    @(negedge clk);
    if (kind == 0) evtTx = m; else if (kind == 1) evtRx = m; else evtOvf = m;
    @(negedge clk);
    evtTx = '0; evtRx = '0; evtOvf = '0;
  endtask

  task automatic finishTest();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog expired");
    finishTest();
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rstN = 1'b1;
    // R11 reset state
    check("R11 irq after reset", {31'b0, irq}, 32'h0);
    rd(6'h20, d); check("R9 ring count", d, N);
    rd(6'h10, d); check("R11 enable reset", d, 32'h0);
    rd(6'h30, d); check("R11 control reset", d, 32'h0);
    // R4 / R10 enable bank and padding
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, d); check("R10 enable padding", d, 32'h00FF_FFFF);
    wr(6'h20, 32'h5);
    rd(6'h20, d); check("R9 count write ignored", d, N);
    rd(6'h11, d); check("R10 enable word past bank", d, 32'h0);
    // R5 / R6 / R1 basic firing
    pulse(0, 12'h008);
    check("R5 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk); check("R5 irq rises", {31'b0, irq}, 32'h1);
    idle(3); check("R6 irq held", {31'b0, irq}, 32'h1);
    rd(6'h00, d); check("R1 tx3 bit", d, 32'h8);
    check("R6 irq dropped by read", {31'b0, irq}, 32'h0);
    rd(6'h00, d); check("R2 cleared on read", d, 32'h0);
    // R7 re-arm rule
    pulse(1, 12'h002);
    idle(4); check("R7 no refire before all words read", {31'b0, irq}, 32'h0);
    rd(6'h01, d); check("R2 word1 empty", d, 32'h0);
    @(negedge clk); check("R7 not yet re-armed", {31'b0, irq}, 32'h0);
    @(negedge clk); check("R7 refire after re-arm", {31'b0, irq}, 32'h1);
    rd(6'h00, d); check("R1 rx1 bit", d, 32'h2000);
    rd(6'h01, d);
    idle(3); check("R7 quiet after clean re-arm", {31'b0, irq}, 32'h0);
    // R4 gating of tx
    wr(6'h10, 32'h00FD_FFFF);
    pulse(0, 12'h020);
    idle(3); check("R4 disabled tx5 no irq", {31'b0, irq}, 32'h0);
    rd(6'h00, d); check("R1 tx5 still latched", d, 32'h20);
    // R4 overflow gated by receive enable
    wr(6'h10, 32'h00FF_FDFF);
    pulse(2, 12'h200);
    idle(3); check("R4 ovf9 gated by rx9", {31'b0, irq}, 32'h0);
    rd(6'h01, d); check("R1 ovf9 in word1", d, 32'h2);
    wr(6'h10, 32'h00FF_FFFF);
    pulse(2, 12'h200);
    @(negedge clk); check("R4 ovf9 enabled fires", {31'b0, irq}, 32'h1);
    rd(6'h00, d);
    rd(6'h01, d); check("R1 ovf9 again", d, 32'h2);
    idle(3);
    // R3 set wins over clear-on-read
    @(negedge clk); rdEn = 1'b1; addr = 6'h00; evtTx = 12'h004;
    @(negedge clk); rdEn = 1'b0; evtTx = '0; d = rdData;
    check("R3 concurrent read returns old", d, 32'h0);
    rd(6'h00, d); check("R3 event kept pending", d, 32'h4);
    rd(6'h01, d);
    idle(3);
    // R8 auto-clear
    wr(6'h30, 32'h4);
    rd(6'h30, d); check("R8 control readback", d, 32'h4);
    pulse(1, 12'h001);
    check("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk); check("R8 irq pulse high", {31'b0, irq}, 32'h1);
    @(negedge clk); check("R8 irq pulse ends", {31'b0, irq}, 32'h0);
    idle(3); check("R8 stays low while disarmed", {31'b0, irq}, 32'h0);
    rd(6'h00, d); check("R8 rx0 pending", d, 32'h1000);
    rd(6'h01, d);
    wr(6'h30, 32'h0);
    idle(3);
    // R1 / R10 overflow spread over two words
    pulse(2, 12'hFFF);
    idle(2);
    rd(6'h00, d); check("R1 ovf0-7 high bits", d, 32'hFF00_0000);
    rd(6'h01, d); check("R10 status padding zero", d, 32'hF);
    rd(6'h02, d); check("R10 status word past bank", d, 32'h0);
    idle(3);
    finishTest();
  end
endmodule